// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM from power-on to a usable state before the main memory controller takes over the command bus. After a synchronous reset it keeps the bus at NOP with the clock enable high for a programmable settling time. It then closes every bank with a precharge-all command. It issues a fixed number of auto refresh commands and writes the mode register with a value supplied on an input. Each command is followed by the NOP gap that the device needs before the next one.

Two orderings are available through a parameter. In the default order the mode register is written after the refresh burst. In the alternative order it is written straight after the precharge, and the refresh burst follows. While the sequence runs, the data mask lines are held high so the device never drives the data bus. Once the last gap has expired, the block raises its done flag and keeps it high until the next reset, with the bus idle and the mask released. The controller uses that flag to take ownership of the command pins.

Top module: `sdram_init`

## Requirements
- R1: While reset is applied, the bus shows NOP (CS, RAS, CAS, WE = 0,1,1,1), the clock enable is high, every mask bit is high and the done flag is low.
- R2: After reset is released, the bus stays at NOP for T_WAIT cycles. The first command is precharge-all (CS, RAS, CAS, WE = 0,0,1,0 with address bit PRE_ALL_BIT high), and it appears T_WAIT cycles after the last reset edge.
- R3: The command after the precharge appears exactly T_RP cycles after it.
- R4: Exactly N_REF auto refresh commands (0,0,0,1) are issued, and consecutive refreshes are T_RC cycles apart.
- R5: The mode load command (0,0,0,0) carries the mode input value on the address bus, with the bank select at zero.
- R6: In the default order (MODE_FIRST=0), the mode load comes T_RC cycles after the last refresh, and the done flag rises T_MRD cycles after the mode load.
- R7: In the alternative order (MODE_FIRST=1), the mode load comes T_RP cycles after the precharge, the first refresh comes T_MRD cycles after it, and the done flag rises T_RC cycles after the last refresh.
- R8: Every cycle that carries no sequence command is a NOP, so a full run shows exactly N_REF+2 non-NOP commands.
- R9: During the sequence, every mask bit is high. Once the done flag is high, every mask bit is low. The clock enable is high in every cycle.
- R10: Once the done flag is high, it stays high and the bus stays at NOP until the next reset.
- R11: A reset applied mid-sequence restarts it from the settling wait, and the next mode load uses the mode value present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| mode_code_i | input | ADDR_W | Value written to the mode register |
| sd_cke_o | output | 1 | Clock enable to the device |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_addr_o | output | ADDR_W | Address bus |
| sd_ba_o | output | BANK_W | Bank select |
| sd_dqm_o | output | DQM_W | Data mask, one bit per byte lane |
| init_done_o | output | 1 | High once the sequence is complete |

## Verification
The assertions assume that reset is held for at least one clock edge before the sequence is judged. They also assume that every gap parameter is at least two cycles, which is what keeps a NOP between any two commands, and that the mode value does not change in the cycle a mode load is built. The stimulus meets these conditions. It starts with reset applied, uses gaps of two cycles or more, and changes the mode value only while reset is held. Two instances, one for each ordering, run side by side from the same stimulus, and a mid-sequence reset is applied to both.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command encoding is the pin pattern {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        S_WAIT = 3'd0,
        S_PRE  = 3'd1,
        S_TRP  = 3'd2,
        S_REF  = 3'd3,
        S_TRC  = 3'd4,
        S_MRS  = 3'd5,
        S_TMRD = 3'd6,
        S_DONE = 3'd7
    } state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // A running count moves down by exactly one per cycle (gap lengths, R3)
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // A load takes effect on the next edge (gap lengths, R4)
    p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PRE_ALL_BIT = 10,
    parameter int CNT_W       = 16,
    parameter int T_RP        = 3,
    parameter int T_RC        = 7,
    parameter int T_MRD       = 2,
    parameter int N_REF       = 8,
    parameter bit MODE_FIRST  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_code_i,
    input  logic              timer_zero_i,
    output logic              timer_load_o,
    output logic [CNT_W-1:0]  timer_val_o,
    output cmd_e              cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam int REF_W = $clog2(N_REF + 1);

    typedef struct packed {
        state_e            state;
        logic [REF_W-1:0]  ref_left;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    // Successor of each step, chosen by the ordering parameter
    state_e after_pre, after_mrs, after_ref;

    generate
        if (MODE_FIRST) begin : g_mode_first
            assign after_pre = S_MRS;
            assign after_mrs = S_REF;
            assign after_ref = S_DONE;
        end else begin : g_mode_last
            assign after_pre = S_REF;
            assign after_mrs = S_DONE;
            assign after_ref = S_MRS;
        end
    endgenerate

    always_comb begin
        s_d          = s_q;
        timer_load_o = 1'b0;
        timer_val_o  = '0;

        case (s_q.state)
            S_WAIT: begin
                if (timer_zero_i) s_d.state = S_PRE;
            end
            S_PRE: begin
                timer_load_o = 1'b1;
                timer_val_o  = CNT_W'(T_RP - 2);
                s_d.state    = S_TRP;
            end
            S_TRP: begin
                if (timer_zero_i) s_d.state = after_pre;
            end
            S_REF: begin
                timer_load_o = 1'b1;
                timer_val_o  = CNT_W'(T_RC - 2);
                s_d.ref_left = s_q.ref_left - 1'b1;
                s_d.state    = S_TRC;
            end
            S_TRC: begin
                if (timer_zero_i) begin
                    s_d.state = (s_q.ref_left != '0) ? S_REF : after_ref;
                end
            end
            S_MRS: begin
                timer_load_o = 1'b1;
                timer_val_o  = CNT_W'(T_MRD - 2);
                s_d.state    = S_TMRD;
            end
            S_TMRD: begin
                if (timer_zero_i) s_d.state = after_mrs;
            end
            S_DONE: begin
                s_d.state = S_DONE;
            end
            default: begin
                s_d.state = S_WAIT;
            end
        endcase

        // Bus image registered together with the state it belongs to
        s_d.cmd  = CMD_NOP;
        s_d.addr = '0;
        case (s_d.state)
            S_PRE: begin
                s_d.cmd               = CMD_PRE;
                s_d.addr[PRE_ALL_BIT] = 1'b1;
            end
            S_REF: begin
                s_d.cmd = CMD_REF;
            end
            S_MRS: begin
                s_d.cmd  = CMD_MRS;
                s_d.addr = mode_code_i;
            end
            default: begin
                s_d.cmd = CMD_NOP;
            end
        endcase
        s_d.done = (s_d.state == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.state    <= S_WAIT;
            s_q.ref_left <= REF_W'(N_REF);
            s_q.cmd      <= CMD_NOP;
            s_q.addr     <= '0;
            s_q.done     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o  = s_q.cmd;
    assign addr_o = s_q.addr;
    assign done_o = s_q.done;

    // A command is always followed by at least one NOP (R8)
    p_nop_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (s_q.cmd != CMD_NOP) |=> (s_q.cmd == CMD_NOP));

    // Precharge always selects all banks (R2)
    p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
        (s_q.cmd == CMD_PRE) |-> s_q.addr[PRE_ALL_BIT]);

    // Refresh budget never grows past its start value (R4)
    p_ref_budget_r4: assert property (@(posedge clk) disable iff (rst)
        (s_q.ref_left <= REF_W'(N_REF)));

    // A refresh consumes exactly one unit of budget (R4)
    p_ref_spend_r4: assert property (@(posedge clk) disable iff (rst)
        (s_q.cmd == CMD_REF) |=> (s_q.ref_left == $past(s_q.ref_left) - 1'b1));

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int DQM_W = 2
) (
    input  cmd_e             cmd_i,
    input  logic             done_i,
    output logic             cke_o,
    output logic             cs_n_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [DQM_W-1:0] dqm_o
);

    assign cke_o = 1'b1;
    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_i;

    generate
        for (genvar lane = 0; lane < DQM_W; lane++) begin : g_lane
            assign dqm_o[lane] = ~done_i;
        end
    endgenerate

endmodule

// File: rtl/sdram_init.sv
module sdram_init
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BANK_W      = 2,
    parameter int DQM_W       = 2,
    parameter int PRE_ALL_BIT = 10,
    parameter int T_WAIT      = 20000,
    parameter int T_RP        = 3,
    parameter int T_RC        = 7,
    parameter int T_MRD       = 2,
    parameter int N_REF       = 8,
    parameter bit MODE_FIRST  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_code_i,
    output logic              sd_cke_o,
    output logic              sd_cs_n_o,
    output logic              sd_ras_n_o,
    output logic              sd_cas_n_o,
    output logic              sd_we_n_o,
    output logic [ADDR_W-1:0] sd_addr_o,
    output logic [BANK_W-1:0] sd_ba_o,
    output logic [DQM_W-1:0]  sd_dqm_o,
    output logic              init_done_o
);

    localparam int MAX_A = (T_WAIT > T_RC) ? T_WAIT : T_RC;
    localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_zero;
    cmd_e             cmd;
    logic             done;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (T_WAIT - 1)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .zero_o     (timer_zero)
    );

    sdram_init_seq #(
        .ADDR_W      (ADDR_W),
        .PRE_ALL_BIT (PRE_ALL_BIT),
        .CNT_W       (CNT_W),
        .T_RP        (T_RP),
        .T_RC        (T_RC),
        .T_MRD       (T_MRD),
        .N_REF       (N_REF),
        .MODE_FIRST  (MODE_FIRST)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .mode_code_i  (mode_code_i),
        .timer_zero_i (timer_zero),
        .timer_load_o (timer_load),
        .timer_val_o  (timer_val),
        .cmd_o        (cmd),
        .addr_o       (sd_addr_o),
        .done_o       (done)
    );

    sdram_init_pins #(
        .DQM_W (DQM_W)
    ) u_pins (
        .cmd_i   (cmd),
        .done_i  (done),
        .cke_o   (sd_cke_o),
        .cs_n_o  (sd_cs_n_o),
        .ras_n_o (sd_ras_n_o),
        .cas_n_o (sd_cas_n_o),
        .we_n_o  (sd_we_n_o),
        .dqm_o   (sd_dqm_o)
    );

    assign sd_ba_o     = '0;
    assign init_done_o = done;

    // Mask held high throughout the sequence (R9)
    p_dqm_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !init_done_o |-> (&sd_dqm_o));

    // Done never drops without a reset (R10)
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);

    // After completion the bus is idle and the mask released (R10)
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> ({sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} == 4'b0111
                         && sd_dqm_o == '0));

    // Mode load goes to bank zero (R5)
    p_mode_bank_r5: assert property (@(posedge clk) disable iff (rst)
        ({sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} == 4'b0000) |-> (sd_ba_o == '0));

endmodule

// File: tb/sdram_init_tb.sv
`timescale 1ns/1ps
module sdram_init_tb;

    localparam int AW = 12, BW = 2, DW = 2;
    localparam int TW = 20, TRP = 3, TRC = 5, TMRD = 2, NREF = 8;
    localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010,
                           P_REF = 4'b0001, P_MRS = 4'b0000;

    typedef struct packed {
        logic [7:0] cyc;
        logic       alt;
        logic [3:0] pins;
        logic [3:0] req;
    } vec_t;

    // Expected commands, sorted by cycle; alt=1 is the mode-first instance
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'd20, 1'b0, P_PRE, 4'd2},   // R2
        '{8'd20, 1'b1, P_PRE, 4'd2},   // R2
        '{8'd23, 1'b0, P_REF, 4'd3},   // R3
        '{8'd23, 1'b1, P_MRS, 4'd7},   // R7 (also R3)
        '{8'd25, 1'b1, P_REF, 4'd7},   // R7
        '{8'd28, 1'b0, P_REF, 4'd4},   // R4
        '{8'd30, 1'b1, P_REF, 4'd4},
        '{8'd33, 1'b0, P_REF, 4'd4},
        '{8'd35, 1'b1, P_REF, 4'd4},
        '{8'd38, 1'b0, P_REF, 4'd4},
        '{8'd40, 1'b1, P_REF, 4'd4},
        '{8'd43, 1'b0, P_REF, 4'd4},
        '{8'd45, 1'b1, P_REF, 4'd4},
        '{8'd48, 1'b0, P_REF, 4'd4},
        '{8'd50, 1'b1, P_REF, 4'd4},
        '{8'd53, 1'b0, P_REF, 4'd4},
        '{8'd55, 1'b1, P_REF, 4'd4},
        '{8'd58, 1'b0, P_REF, 4'd4},
        '{8'd60, 1'b1, P_REF, 4'd4},
        '{8'd63, 1'b0, P_MRS, 4'd6}    // R6 (also R5)
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mode_code = 12'h032;

    logic          m_cke, m_cs, m_ras, m_cas, m_we, m_done;
    logic [AW-1:0] m_addr;
    logic [BW-1:0] m_ba;
    logic [DW-1:0] m_dqm;
    logic          a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [AW-1:0] a_addr;
    logic [BW-1:0] a_ba;
    logic [DW-1:0] a_dqm;
    logic [3:0]    m_pins, a_pins;

    assign m_pins = {m_cs, m_ras, m_cas, m_we};
    assign a_pins = {a_cs, a_ras, a_cas, a_we};

    sdram_init #(
        .ADDR_W(AW), .BANK_W(BW), .DQM_W(DW), .PRE_ALL_BIT(10),
        .T_WAIT(TW), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .N_REF(NREF),
        .MODE_FIRST(1'b0)
    ) u_dut (
        .clk(clk), .rst(rst), .mode_code_i(mode_code),
        .sd_cke_o(m_cke), .sd_cs_n_o(m_cs), .sd_ras_n_o(m_ras),
        .sd_cas_n_o(m_cas), .sd_we_n_o(m_we), .sd_addr_o(m_addr),
        .sd_ba_o(m_ba), .sd_dqm_o(m_dqm), .init_done_o(m_done)
    );

    sdram_init #(
        .ADDR_W(AW), .BANK_W(BW), .DQM_W(DW), .PRE_ALL_BIT(10),
        .T_WAIT(TW), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .N_REF(NREF),
        .MODE_FIRST(1'b1)
    ) u_dut_alt (
        .clk(clk), .rst(rst), .mode_code_i(mode_code),
        .sd_cke_o(a_cke), .sd_cs_n_o(a_cs), .sd_ras_n_o(a_ras),
        .sd_cas_n_o(a_cas), .sd_we_n_o(a_we), .sd_addr_o(a_addr),
        .sd_ba_o(a_ba), .sd_dqm_o(a_dqm), .init_done_o(a_done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m_cmds = 0, a_cmds = 0, m_viol = 0, a_viol = 0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Per-cycle monitor for command count (R8) and mask/enable levels (R9)
    always @(negedge clk) begin
        if (rst) begin
            m_cmds = 0; a_cmds = 0; m_viol = 0; a_viol = 0;
        end else begin
            if (m_pins != P_NOP) m_cmds++;
            if (a_pins != P_NOP) a_cmds++;
            if (m_cke !== 1'b1 || m_dqm !== (m_done ? 2'b00 : 2'b11)) m_viol++;
            if (a_cke !== 1'b1 || a_dqm !== (a_done ? 2'b00 : 2'b11)) a_viol++;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        check("R1", "main pins", {28'd0, m_pins}, {28'd0, P_NOP});
        check("R1", "alt pins",  {28'd0, a_pins}, {28'd0, P_NOP});
        check("R1", "cke/dqm/done", {28'd0, m_cke, m_dqm, m_done}, 32'b1110);
        check("R1", "alt cke/dqm/done", {28'd0, a_cke, a_dqm, a_done}, 32'b1110);
        rst = 1'b0;

        // R2: still idle one cycle before the precharge
        wait_cyc(TW - 1);
        check("R2", "idle before precharge", {28'd0, m_pins}, {28'd0, P_NOP});

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            wait_cyc(int'(VECS[i].cyc));
            if (VECS[i].alt) begin
                check($sformatf("R%0d", VECS[i].req), "alt cmd",
                      {28'd0, a_pins}, {28'd0, VECS[i].pins});
                if (VECS[i].pins == P_PRE)
                    check("R2", "alt A10", {31'd0, a_addr[10]}, 32'd1);
                if (VECS[i].pins == P_MRS) begin
                    check("R5", "alt mode addr", {20'd0, a_addr}, {20'd0, mode_code});
                    check("R5", "alt mode bank", {30'd0, a_ba}, 32'd0);
                end
            end else begin
                check($sformatf("R%0d", VECS[i].req), "main cmd",
                      {28'd0, m_pins}, {28'd0, VECS[i].pins});
                if (VECS[i].pins == P_PRE)
                    check("R2", "main A10", {31'd0, m_addr[10]}, 32'd1);
                if (VECS[i].pins == P_MRS) begin
                    check("R5", "main mode addr", {20'd0, m_addr}, {20'd0, mode_code});
                    check("R5", "main mode bank", {30'd0, m_ba}, 32'd0);
                end
            end
        end

        // R6 / R7: done timing
        wait_cyc(64);
        check("R6", "main done early", {31'd0, m_done}, 32'd0);
        check("R7", "alt done early",  {31'd0, a_done}, 32'd0);
        wait_cyc(65);
        check("R6", "main done", {31'd0, m_done}, 32'd1);
        check("R7", "alt done",  {31'd0, a_done}, 32'd1);

        // R10: sticky done, idle bus, mask released
        wait_cyc(85);
        check("R10", "main done held", {31'd0, m_done}, 32'd1);
        check("R10", "alt done held",  {31'd0, a_done}, 32'd1);
        check("R10", "main idle", {28'd0, m_pins}, {28'd0, P_NOP});
        check("R9",  "main dqm released", {30'd0, m_dqm}, 32'd0);

        // R8 / R9: whole-run monitor results
        check("R8", "main command count", m_cmds, NREF + 2);
        check("R8", "alt command count",  a_cmds, NREF + 2);
        check("R9", "main mask/cke level", m_viol, 0);
        check("R9", "alt mask/cke level",  a_viol, 0);

        // R11: reset mid-sequence, new mode value
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11", "done cleared", {31'd0, m_done}, 32'd0);
        mode_code = 12'h027;
        rst = 1'b0;
        wait_cyc(30);
        rst = 1'b1;
        @(negedge clk);
        check("R11", "bus idle in reset", {28'd0, m_pins}, {28'd0, P_NOP});
        check("R11", "mask high in reset", {30'd0, m_dqm}, 32'd3);
        rst = 1'b0;
        wait_cyc(TW - 1);
        check("R11", "restart idle", {28'd0, m_pins}, {28'd0, P_NOP});
        wait_cyc(TW);
        check("R11", "restart precharge", {28'd0, m_pins}, {28'd0, P_PRE});
        check("R11", "alt restart precharge", {28'd0, a_pins}, {28'd0, P_PRE});
        wait_cyc(23);
        check("R11", "alt new mode addr", {20'd0, a_addr}, 32'h027);
        wait_cyc(63);
        check("R11", "main new mode addr", {20'd0, m_addr}, 32'h027);
        wait_cyc(65);
        check("R11", "main done after restart", {31'd0, m_done}, 32'd1);
        wait_cyc(70);
        check("R8", "main restart count", m_cmds, NREF + 2);
        check("R9", "main restart level", m_viol, 0);

        finish_run();
    end

endmodule